// File: doc/BRIEF.md
# Prioritized 64-Source Interrupt Controller

This block collects 64 level-sensitive interrupt request lines and presents one request at a time to the processor. It reports the request as a priority level and a vector number. Each source has a programmable priority byte. A nonzero byte enables the source and a zero byte disables it. A 64-bit mask register can hide any source. The mask can be written as two 32-bit halves, or changed one bit at a time through a set port and a clear port. Each of those ports also has an "all bits" flag.

The controller re-arbitrates on every clock. Among the unmasked, enabled sources whose request or force bit is set, the largest priority byte wins. When two bytes are equal, the higher-numbered source wins. The vector is the winning index plus 64. When nothing is active, the vector is 24 and the level is 0. Software can read the current vector from an acknowledge register.

The register port is byte-addressed, with 32-bit data and a 256-byte window. A read strobe is sampled on a clock edge, and the data returns with a one-cycle valid pulse. The port accepts one read and one write per cycle and never stalls, so it has no back-pressure. The level and vector outputs are plain registered status pins.

Top module: `irqc_top`

## Requirements
- R1: After reset, every mask bit is 1, pending and force read 0, every priority byte reads 0, the level is 0 and the vector is 24.
- R2: The pending register follows the request inputs each clock. Offset 0x00 reads bits 63:32 and offset 0x04 reads bits 31:0. Writes to 0x00 and 0x04 are ignored.
- R3: A source is active only when its pending or force bit is 1, its priority byte is nonzero, and its mask bit is 0. Writing zero to a priority byte disables the source.
- R4: The active source with the largest priority byte wins. On a tie, the source with the higher index wins.
- R5: The level output equals the winner's priority byte and the vector equals the winner index plus 64. With no active source, the level is 0 and the vector is 24.
- R6: Offset 0x08 reads and writes mask bits 63:32, and offset 0x0C reads and writes mask bits 31:0.
- R7: A write to 0x1C sets the mask bit indexed by wdata[5:0]. If wdata[6] is 1, the write sets all 64 mask bits instead.
- R8: A write to 0x1D clears the mask bit indexed by wdata[5:0]. If wdata[6] is 1, the write clears all 64 mask bits instead.
- R9: Offsets 0x40 to 0x7F hold the priority bytes of sources 0 to 63. A write stores wdata[7:0], and a read returns the byte zero-extended.
- R10: A read of 0xE0 returns the current vector. Offsets 0x10 and 0x14 read the upper and lower force halves, which no write changes. Every other offset, including 0x1C and 0x1D, reads 0.
- R11: Writes to unmapped offsets change no register.
- R12: Read data and rd_valid_o appear one clock after the read strobe. The level and vector change one clock after the registers they depend on change. A write or input change sampled at edge k therefore shows at the outputs after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 64 | Level-sensitive request lines |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte offset in the register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rd_valid_o |
| rd_valid_o | output | 1 | Pulses one clock after rd_en_i |
| level_o | output | 8 | Priority byte of the winning source, 0 when idle |
| vector_o | output | 8 | Winner index plus 64, or 24 when idle |

## Verification
The bench targets equal-priority ties between sources 5 and 40. A design that lets the first match win would report vector 69 where 104 is expected. It checks that zeroing a priority byte drops a pending source, which catches a design that keeps the enable bit sticky. It drives both mask shortcut ports in single-bit and all-bits form, including index 63, to expose a wrong index width or an ignored flag. It also writes to the pending, force and unmapped offsets and reads the state back, and it measures the exact cycle in which level and vector move after a write and after an input change, which catches a missing or extra pipeline stage.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int N_SRC    = 64;
  localparam int IDX_W    = $clog2(N_SRC);
  localparam int PRIO_W   = 8;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int VEC_W    = 8;
  localparam int VEC_BASE = 64;
  localparam int VEC_NONE = 24;

  localparam logic [ADDR_W-1:0] OFF_PEND_HI  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_PEND_LO  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_MASK_HI  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_MASK_LO  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_FORCE_HI = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_FORCE_LO = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_MSET     = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_MCLR     = 8'h1D;
  localparam logic [ADDR_W-1:0] OFF_ACK      = 8'hE0;
  localparam logic [ADDR_W-1:0] OFF_PRIO     = 8'h40;

  typedef struct packed {
    logic              valid;
    logic [IDX_W-1:0]  idx;
    logic [PRIO_W-1:0] lvl;
  } win_t;

  // Offsets that return a value on a read.
  function automatic logic is_readable(input logic [ADDR_W-1:0] a);
    return (a[7:6] == 2'b01) || (a == OFF_PEND_HI) || (a == OFF_PEND_LO) ||
           (a == OFF_MASK_HI) || (a == OFF_MASK_LO) || (a == OFF_FORCE_HI) ||
           (a == OFF_FORCE_LO) || (a == OFF_ACK);
  endfunction
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_SRC-1:0]              irq_i,
  input  logic                          wr_en_i,
  input  logic                          rd_en_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [VEC_W-1:0]              vector_i,
  output logic [DATA_W-1:0]             rdata_o,
  output logic                          rd_valid_o,
  output logic [N_SRC-1:0]              pend_o,
  output logic [N_SRC-1:0]              mask_o,
  output logic [N_SRC-1:0]              force_o,
  output logic [N_SRC-1:0][PRIO_W-1:0]  prio_o
);
  logic [N_SRC-1:0]             pend_q, mask_q, force_q;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [DATA_W-1:0]            rd_mux, rdata_q;
  logic                         rvalid_q;

  // Pending bits track the request lines.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= irq_i;
  end

  // No offset writes the force register; it keeps its reset value.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) force_q <= '0;
    else         force_q <= force_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
    end else if (wr_en_i) begin
      unique case (addr_i)
        OFF_MASK_HI: mask_q[63:32] <= wdata_i;
        OFF_MASK_LO: mask_q[31:0]  <= wdata_i;
        OFF_MSET: begin
          if (wdata_i[6]) mask_q <= '1;
          else            mask_q[wdata_i[IDX_W-1:0]] <= 1'b1;
        end
        OFF_MCLR: begin
          if (wdata_i[6]) mask_q <= '0;
          else            mask_q[wdata_i[IDX_W-1:0]] <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_prio
    localparam logic [ADDR_W-1:0] MY_OFF = OFF_PRIO + ADDR_W'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          prio_q[g] <= '0;
      else if (wr_en_i && addr_i == MY_OFF) prio_q[g] <= wdata_i[PRIO_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i[7:6] == 2'b01) begin
      rd_mux = DATA_W'(prio_q[addr_i[IDX_W-1:0]]);
    end else begin
      unique case (addr_i)
        OFF_PEND_HI:  rd_mux = pend_q[63:32];
        OFF_PEND_LO:  rd_mux = pend_q[31:0];
        OFF_MASK_HI:  rd_mux = mask_q[63:32];
        OFF_MASK_LO:  rd_mux = mask_q[31:0];
        OFF_FORCE_HI: rd_mux = force_q[63:32];
        OFF_FORCE_LO: rd_mux = force_q[31:0];
        OFF_ACK:      rd_mux = DATA_W'(vector_i);
        default:      rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rd_en_i ? rd_mux : '0;
      rvalid_q <= rd_en_i;
    end
  end

  assign rdata_o    = rdata_q;
  assign rd_valid_o = rvalid_q;
  assign pend_o     = pend_q;
  assign mask_o     = mask_q;
  assign force_o    = force_q;
  assign prio_o     = prio_q;
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
(
  input  logic [N_SRC-1:0]             active_i,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
  output win_t                         win_o
);
  always_comb begin
    win_o = '0;
    // Ascending scan with >=: a later (higher) index takes equal priority.
    for (int i = 0; i < N_SRC; i++) begin
      if (active_i[i] && prio_i[i] >= win_o.lvl) begin
        win_o.valid = 1'b1;
        win_o.idx   = IDX_W'(i);
        win_o.lvl   = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [63:0]       irq_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [7:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              rd_valid_o,
  output logic [7:0]        level_o,
  output logic [7:0]        vector_o
);
  logic [N_SRC-1:0]             pend_w, mask_w, force_w, enable_w, active_w;
  logic [N_SRC-1:0][PRIO_W-1:0] prio_w;
  win_t                         win_w;
  logic [PRIO_W-1:0]            level_q;
  logic [VEC_W-1:0]             vector_q;

  irqc_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_i      (irq_i),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .vector_i   (vector_q),
    .rdata_o    (rdata_o),
    .rd_valid_o (rd_valid_o),
    .pend_o     (pend_w),
    .mask_o     (mask_w),
    .force_o    (force_w),
    .prio_o     (prio_w)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_en
    assign enable_w[g] = |prio_w[g];
  end

  assign active_w = (pend_w | force_w) & enable_w & ~mask_w;

  irqc_arbiter u_arb (
    .active_i (active_w),
    .prio_i   (prio_w),
    .win_o    (win_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q  <= '0;
      vector_q <= VEC_W'(VEC_NONE);
    end else if (win_w.valid) begin
      level_q  <= win_w.lvl;
      vector_q <= VEC_W'(VEC_BASE) + VEC_W'(win_w.idx);
    end else begin
      level_q  <= '0;
      vector_q <= VEC_W'(VEC_NONE);
    end
  end

  assign level_o  = level_q;
  assign vector_o = vector_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [63:0]       irq_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [7:0]        addr_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              rd_valid_o,
  input logic [7:0]        level_o,
  input logic [7:0]        vector_o,
  input logic [63:0]       pend_w,
  input logic [63:0]       mask_w
);
  p_pend_follow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pend_w == $past(irq_i));

  p_idle_vector_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o == 8'd0 |-> vector_o == 8'(VEC_NONE));

  p_busy_vector_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o != 8'd0 |-> (vector_o >= 8'(VEC_BASE) && vector_o < 8'(VEC_BASE + N_SRC)));

  p_set_all_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_MSET && wdata_i[6]) |=> mask_w == '1);

  p_set_one_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_MSET && !wdata_i[6]) |=> mask_w[$past(wdata_i[5:0])]);

  p_clr_all_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_MCLR && wdata_i[6]) |=> mask_w == '0);

  p_clr_one_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == OFF_MCLR && !wdata_i[6]) |=> !mask_w[$past(wdata_i[5:0])]);

  p_unmapped_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !is_readable(addr_i)) |=> rdata_o == '0);

  p_read_valid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);

  p_no_spurious_valid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);
endmodule

bind irqc_top irqc_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .irq_i      (irq_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .rd_valid_o (rd_valid_o),
  .level_o    (level_o),
  .vector_o   (vector_o),
  .pend_w     (pend_w),
  .mask_w     (mask_w)
);

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid;
  logic [7:0]  level;
  logic [7:0]  vector;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  irqc_top dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .irq_i      (irq),
    .wr_en_i    (wr_en),
    .rd_en_i    (rd_en),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .rd_valid_o (rd_valid),
    .level_o    (level),
    .vector_o   (vector)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_out(input string req, input int lvl, input int vec);
    check({req, " level"}, 32'(level), 32'(lvl));
    check({req, " vector"}, 32'(vector), 32'(vec));
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    item_t it;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    it.exp = exp; it.req = req;
    sb_q.push_back(it);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pops one expected item per valid read beat.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R12: actual unexpected read beat %h expected none", rdata);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(it.req, rdata, it.exp);
      end
    end
  end

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_out("R1", 0, 24);
    rd(8'h00, 32'h0, "R1 pend hi");
    rd(8'h04, 32'h0, "R1 pend lo");
    rd(8'h08, 32'hFFFF_FFFF, "R1 mask hi");
    rd(8'h0C, 32'hFFFF_FFFF, "R1 mask lo");
    rd(8'h10, 32'h0, "R1 force hi");
    rd(8'h14, 32'h0, "R1 force lo");
    rd(8'h40, 32'h0, "R1 prio0");
    rd(8'hE0, 32'd24, "R1 ack");

    // R2 pending tracks inputs, writes ignored
    @(negedge clk); irq[5] = 1'b1;
    settle();
    rd(8'h04, 32'h20, "R2 pend lo");
    rd(8'h00, 32'h0, "R2 pend hi");
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h04, 32'h20, "R2 pend lo after write");
    rd(8'h00, 32'h0, "R2 pend hi after write");
    check_out("R3 masked and disabled", 0, 24);

    // R3/R8/R5 enable then unmask one source
    wr(8'h45, 32'd3);
    settle();
    check_out("R3 still masked", 0, 24);
    wr(8'h1D, 32'd5);
    settle();
    check_out("R5 source5", 3, 69);
    rd(8'h0C, 32'hFFFF_FFDF, "R8 clear bit5");
    rd(8'h45, 32'd3, "R9 prio5");

    // R4 tie: higher index wins
    @(negedge clk); irq[40] = 1'b1;
    wr(8'h68, 32'd3);
    wr(8'h1D, 32'd40);
    settle();
    check_out("R4 tie", 3, 104);
    rd(8'h08, 32'hFFFF_FEFF, "R8 clear bit40");

    wr(8'h45, 32'd7);
    settle();
    check_out("R4 larger prio", 7, 69);

    // R3 zero priority disables; R9 byte only
    wr(8'h45, 32'd0);
    settle();
    check_out("R3 disabled by zero prio", 3, 104);
    rd(8'h45, 32'h0, "R9 prio5 zero");
    wr(8'h45, 32'h0000_01FF);
    rd(8'h45, 32'h0000_00FF, "R9 byte width");
    wr(8'h45, 32'd0);
    settle();

    // R2/R5 input drop
    @(negedge clk); irq[40] = 1'b0;
    settle();
    check_out("R2 input low", 0, 24);
    rd(8'hE0, 32'd24, "R10 ack idle");

    // R8 clear all, R10 ack of source 63
    wr(8'h1D, 32'h40);
    rd(8'h08, 32'h0, "R8 clear all hi");
    rd(8'h0C, 32'h0, "R8 clear all lo");
    @(negedge clk); irq[63] = 1'b1;
    wr(8'h7F, 32'd1);
    settle();
    check_out("R5 source63", 1, 127);
    rd(8'hE0, 32'd127, "R10 ack 127");

    // R7 set all
    wr(8'h1C, 32'h40);
    settle();
    check_out("R7 set all", 0, 24);
    rd(8'h0C, 32'hFFFF_FFFF, "R7 set all lo");
    rd(8'h08, 32'hFFFF_FFFF, "R7 set all hi");

    // R7 single bit 63
    wr(8'h1D, 32'h40);
    wr(8'h1C, 32'h3F);
    settle();
    rd(8'h08, 32'h8000_0000, "R7 set bit63 hi");
    rd(8'h0C, 32'h0, "R7 set bit63 lo");
    check_out("R7 source63 masked", 0, 24);

    // R6 mask halves
    wr(8'h08, 32'h0);
    wr(8'h0C, 32'h0000_1234);
    settle();
    rd(8'h08, 32'h0, "R6 mask hi");
    rd(8'h0C, 32'h0000_1234, "R6 mask lo");
    check_out("R6 unmask 63", 1, 127);

    // R11 unmapped and read-only writes; R10 unmapped reads
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h88, 32'hFFFF_FFFF);
    wr(8'hE0, 32'h0);
    settle();
    rd(8'h10, 32'h0, "R10 force hi");
    rd(8'h14, 32'h0, "R10 force lo");
    rd(8'h08, 32'h0, "R11 mask hi kept");
    rd(8'h0C, 32'h0000_1234, "R11 mask lo kept");
    check_out("R11 outputs kept", 1, 127);
    rd(8'h30, 32'h0, "R10 unmapped read");
    rd(8'h1C, 32'h0, "R10 set port reads zero");
    rd(8'h88, 32'h0, "R10 high unmapped read");

    // R12 latency of a write
    @(negedge clk); irq[10] = 1'b1;
    settle();
    wr(8'h4A, 32'd2);
    check_out("R12 one edge after write", 1, 127);
    @(negedge clk);
    check_out("R12 two edges after write", 2, 74);

    // R12 latency of an input change
    @(negedge clk); irq[10] = 1'b0;
    @(negedge clk);
    check_out("R12 one edge after input", 2, 74);
    @(negedge clk);
    check_out("R12 two edges after input", 1, 127);

    settle();
    check("R12 all reads returned", 32'(sb_q.size()), 32'd0);
    done = 1'b1;
    report();
  end
endmodule